// File: doc/BRIEF.md
# Single-Cycle 32-bit Processor Core

This block is a small 32-bit processor that completes every instruction in one clock cycle. A program counter addresses an internal instruction store. Decode, register read, arithmetic, data access and register write-back all settle combinationally within the cycle. The program counter, the register bank and the data store are updated together on the next rising edge. The supported operations are register add, subtract, AND, OR and signed set-less-than, OR with a 16-bit immediate, word load, word store, branch-if-equal and absolute jump.

Both stores are word-addressed arrays inside the block. A test harness fills them through a load port while the core is held in reset. Each store write performed by a running program is also presented on output pins, so the program's results can be observed from outside. The reset is asynchronous and active low. Its release is synchronised internally, so the core starts fetching at address 0 two cycles after `rst_n` rises.

Top module: `onecyc_cpu`

## Requirements
- R1: While the core is in reset, `pc_o` reads 0 and `dwr_en_o` is low. After release, the first instruction fetched is the one at address 0.
- R2: Instructions are 32 bits. The opcode is in bits 31:26, the first source register in 25:21 and the second source (or I-form destination) in 20:16. The R-form destination is in 15:11 and the R-form function code in 5:0. A 16-bit immediate sits in 15:0 and a 26-bit jump field in 25:0.
- R3: Opcode 0x00 with function 0x20, 0x22, 0x24 or 0x25 writes the destination with the sum, difference (first minus second), bitwise AND or bitwise OR of the two source registers.
- R4: Opcode 0x00 with function 0x2A writes 1 to the destination when the first source is less than the second as two's-complement numbers, and 0 otherwise.
- R5: Opcode 0x0D writes register[bits 20:16] with the first source ORed with the immediate zero-extended to 32 bits.
- R6: Opcode 0x23 loads register[bits 20:16] from the data word at the first source plus the sign-extended immediate. Opcode 0x2B stores register[bits 20:16] to that byte address. A store drives `dwr_en_o` high with the address and data for that cycle, and no other instruction drives it high.
- R7: Opcode 0x04 sets the next PC to PC+4 plus the sign-extended immediate times 4 when both sources are equal, and to PC+4 otherwise.
- R8: Opcode 0x02 sets the next PC to the upper four bits of PC+4, then the 26-bit field, then two zero bits. A jump to its own address holds the PC there.
- R9: Register 0 always reads as zero, and an instruction that targets it leaves it zero.
- R10: Every other instruction advances the PC by 4. An opcode not listed here changes no register and no data word.
- R11: With `load_en` high, `load_data` is written on the clock edge into word `load_addr` of the data store when `load_dmem` is 1, and of the instruction store when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| load_en | input | 1 | Write one word into a store this cycle |
| load_dmem | input | 1 | Store select for loading: 1 data, 0 instruction |
| load_addr | input | LD_AW | Word index for the load write |
| load_data | input | 32 | Word written by the load port |
| pc_o | output | 32 | Current program counter |
| dwr_en_o | output | 1 | A store instruction is executing this cycle |
| dwr_addr_o | output | 32 | Byte address of the store |
| dwr_data_o | output | 32 | Data being stored |

## Verification
The checker watches the next-PC selection on every cycle: sequential advance, jump target formation, and taken and untaken branches. It also checks that a read of register 0 returns zero and that the store strobe appears only for the store opcode. The arithmetic results, the signed comparison, zero versus sign extension, and the rule that unknown opcodes and writes to register 0 have no effect show up only at the store outputs. Only the bench's programs can show these, running with random and directed operand pairs. Among the directed pairs are ones at the signed boundary and an equal pair that flips the second branch.

// File: rtl/onecyc_pkg.sv
package onecyc_pkg;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_JMP   = 6'h02;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_ORI   = 6'h0D;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_ADD,
    ALU_SUB,
    ALU_AND,
    ALU_OR,
    ALU_SLT
  } alu_op_e;

  typedef struct packed {
    logic    reg_we;
    logic    dst_rd;
    logic    src_imm;
    logic    zext;
    logic    mem_we;
    logic    mem_rd;
    logic    br_eq;
    logic    jmp;
    alu_op_e alu;
  } ctrl_t;

endpackage

// File: rtl/onecyc_decode.sv
module onecyc_decode
  import onecyc_pkg::*;
(
  input  logic [5:0] op,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);

  always_comb begin
    ctrl = '0;
    ctrl.alu = ALU_ADD;
    unique case (op)
      OP_RTYPE: begin
        ctrl.dst_rd = 1'b1;
        ctrl.reg_we = 1'b1;
        unique case (funct)
          FN_ADD:  ctrl.alu = ALU_ADD;
          FN_SUB:  ctrl.alu = ALU_SUB;
          FN_AND:  ctrl.alu = ALU_AND;
          FN_OR:   ctrl.alu = ALU_OR;
          FN_SLT:  ctrl.alu = ALU_SLT;
          default: ctrl.reg_we = 1'b0;
        endcase
      end
      OP_ORI: begin
        ctrl.reg_we  = 1'b1;
        ctrl.src_imm = 1'b1;
        ctrl.zext    = 1'b1;
        ctrl.alu     = ALU_OR;
      end
      OP_LW: begin
        ctrl.reg_we  = 1'b1;
        ctrl.src_imm = 1'b1;
        ctrl.mem_rd  = 1'b1;
      end
      OP_SW: begin
        ctrl.src_imm = 1'b1;
        ctrl.mem_we  = 1'b1;
      end
      OP_BEQ: begin
        ctrl.br_eq = 1'b1;
        ctrl.alu   = ALU_SUB;
      end
      OP_JMP: ctrl.jmp = 1'b1;
      default: ctrl = ctrl;
    endcase
  end

endmodule

// File: rtl/onecyc_alu.sv
module onecyc_alu
  import onecyc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y,
  output logic         zero
);

  logic lt_s;
  assign lt_s = $signed(a) < $signed(b);

  always_comb begin
    unique case (op)
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SLT: y = {{(W-1){1'b0}}, lt_s};
      default: y = a + b;
    endcase
  end

  assign zero = (y == '0);

endmodule

// File: rtl/onecyc_regbank.sv
module onecyc_regbank #(
  parameter int NREG = 32,
  parameter int W    = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic [AW-1:0] ra,
  input  logic [AW-1:0] rb,
  output logic [W-1:0]  rda,
  output logic [W-1:0]  rdb,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd
);

  logic [W-1:0] rq [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == 0) begin : g_zero
      assign rq[g] = '0;
    end else begin : g_store
      logic [W-1:0] q;
      logic         en;
      assign en = we && (wa == AW'(g));
      always_ff @(posedge clk) begin
        if (en) q <= wd;
      end
      assign rq[g] = q;
    end
  end

  assign rda = rq[ra];
  assign rdb = rq[rb];

endmodule

// File: rtl/onecyc_wmem.sv
module onecyc_wmem #(
  parameter int AW = 6,
  parameter int W  = 32,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/onecyc_cpu.sv
module onecyc_cpu
  import onecyc_pkg::*;
#(
  parameter int IM_AW = 6,
  parameter int DM_AW = 6,
  parameter int LD_AW = (IM_AW > DM_AW) ? IM_AW : DM_AW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic             load_dmem,
  input  logic [LD_AW-1:0] load_addr,
  input  logic [31:0]      load_data,
  output logic [31:0]      pc_o,
  output logic             dwr_en_o,
  output logic [31:0]      dwr_addr_o,
  output logic [31:0]      dwr_data_o
);

  localparam int XW = 32;
  localparam int RW = 5;

  // reset synchroniser: asserts at once, releases on clock
  logic rst_meta, core_rst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      core_rst_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      core_rst_n <= rst_meta;
    end
  end

  // program counter
  logic [XW-1:0] pc_q, pc_d;
  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) pc_q <= '0;
    else             pc_q <= pc_d;
  end

  // instruction fetch
  logic [XW-1:0] instr;
  logic          im_we;
  assign im_we = load_en && !load_dmem;

  onecyc_wmem #(.AW(IM_AW), .W(XW)) u_imem (
    .clk   (clk),
    .we    (im_we),
    .waddr (load_addr[IM_AW-1:0]),
    .wdata (load_data),
    .raddr (pc_q[IM_AW+1:2]),
    .rdata (instr)
  );

  // field split
  logic [5:0]    f_op, f_fn;
  logic [RW-1:0] f_rs, f_rt, f_rd;
  logic [15:0]   f_imm;
  logic [25:0]   f_tgt;
  assign f_op  = instr[31:26];
  assign f_rs  = instr[25:21];
  assign f_rt  = instr[20:16];
  assign f_rd  = instr[15:11];
  assign f_fn  = instr[5:0];
  assign f_imm = instr[15:0];
  assign f_tgt = instr[25:0];

  ctrl_t ctrl;
  onecyc_decode u_dec (
    .op    (f_op),
    .funct (f_fn),
    .ctrl  (ctrl)
  );

  // register bank
  logic [XW-1:0] rs_val, rt_val, wb_val;
  logic [RW-1:0] wb_idx;
  logic          rf_we;
  assign rf_we  = ctrl.reg_we && core_rst_n;
  assign wb_idx = ctrl.dst_rd ? f_rd : f_rt;

  onecyc_regbank #(.NREG(32), .W(XW)) u_rf (
    .clk (clk),
    .ra  (f_rs),
    .rb  (f_rt),
    .rda (rs_val),
    .rdb (rt_val),
    .we  (rf_we),
    .wa  (wb_idx),
    .wd  (wb_val)
  );

  // immediate and execute
  logic [XW-1:0] imm_ext, alu_b, alu_y;
  logic          alu_zero;
  assign imm_ext = ctrl.zext ? {16'h0000, f_imm} : {{16{f_imm[15]}}, f_imm};
  assign alu_b   = ctrl.src_imm ? imm_ext : rt_val;

  onecyc_alu #(.W(XW)) u_alu (
    .a    (rs_val),
    .b    (alu_b),
    .op   (ctrl.alu),
    .y    (alu_y),
    .zero (alu_zero)
  );

  // data store
  logic              st_en, dm_we;
  logic [DM_AW-1:0]  dm_waddr;
  logic [XW-1:0]     dm_wdata, dm_rdata;
  assign st_en    = ctrl.mem_we && core_rst_n;
  assign dm_we    = (load_en && load_dmem) || st_en;
  assign dm_waddr = (load_en && load_dmem) ? load_addr[DM_AW-1:0] : alu_y[DM_AW+1:2];
  assign dm_wdata = (load_en && load_dmem) ? load_data : rt_val;

  onecyc_wmem #(.AW(DM_AW), .W(XW)) u_dmem (
    .clk   (clk),
    .we    (dm_we),
    .waddr (dm_waddr),
    .wdata (dm_wdata),
    .raddr (alu_y[DM_AW+1:2]),
    .rdata (dm_rdata)
  );

  assign wb_val = ctrl.mem_rd ? dm_rdata : alu_y;

  // next-PC selection
  logic [XW-1:0] pc_seq, pc_br, pc_jmp;
  assign pc_seq = pc_q + 32'd4;
  assign pc_br  = pc_seq + {imm_ext[XW-3:0], 2'b00};
  assign pc_jmp = {pc_seq[31:28], f_tgt, 2'b00};

  always_comb begin
    if (ctrl.jmp)                    pc_d = pc_jmp;
    else if (ctrl.br_eq && alu_zero) pc_d = pc_br;
    else                             pc_d = pc_seq;
  end

  assign pc_o       = pc_q;
  assign dwr_en_o   = st_en;
  assign dwr_addr_o = alu_y;
  assign dwr_data_o = rt_val;

endmodule

// File: rtl/onecyc_cpu_chk.sv
module onecyc_cpu_chk
  import onecyc_pkg::*;
(
  input logic        clk,
  input logic        core_rst_n,
  input logic [31:0] pc,
  input logic [31:0] instr,
  input logic [31:0] rs_val,
  input logic [31:0] rt_val,
  input logic        dwr_en
);

  logic armed;
  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) armed <= 1'b0;
    else             armed <= 1'b1;
  end

  logic [5:0]  op;
  logic [31:0] seq_exp, jmp_exp, br_exp;
  assign op      = instr[31:26];
  assign seq_exp = pc + 32'd4;
  assign jmp_exp = {seq_exp[31:28], instr[25:0], 2'b00};
  assign br_exp  = seq_exp + {{14{instr[15]}}, instr[15:0], 2'b00};

  assert_seq_pc_R10: assert property (@(posedge clk) disable iff (!core_rst_n)
    (armed && op != OP_BEQ && op != OP_JMP) |=> (pc == $past(seq_exp)));

  assert_jump_pc_R8: assert property (@(posedge clk) disable iff (!core_rst_n)
    (armed && op == OP_JMP) |=> (pc == $past(jmp_exp)));

  assert_beq_taken_R7: assert property (@(posedge clk) disable iff (!core_rst_n)
    (armed && op == OP_BEQ && rs_val == rt_val) |=> (pc == $past(br_exp)));

  assert_beq_fall_R7: assert property (@(posedge clk) disable iff (!core_rst_n)
    (armed && op == OP_BEQ && rs_val != rt_val) |=> (pc == $past(seq_exp)));

  assert_reg0_zero_R9: assert property (@(posedge clk) disable iff (!core_rst_n)
    (armed && instr[25:21] == 5'd0) |-> (rs_val == 32'd0));

  assert_store_only_R6: assert property (@(posedge clk) disable iff (!core_rst_n)
    dwr_en |-> (op == OP_SW));

endmodule

bind onecyc_cpu onecyc_cpu_chk u_chk (
  .clk        (clk),
  .core_rst_n (core_rst_n),
  .pc         (pc_q),
  .instr      (instr),
  .rs_val     (rs_val),
  .rt_val     (rt_val),
  .dwr_en     (dwr_en_o)
);

// File: tb/sim_onecyc_cpu.sv
module sim_onecyc_cpu;

  localparam int CLK_PERIOD = 10;
  localparam int STEPS      = 36;
  localparam logic [15:0] ORI_K = 16'hF00F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_en = 1'b0;
  logic        load_dmem = 1'b0;
  logic [5:0]  load_addr = '0;
  logic [31:0] load_data = '0;
  logic [31:0] pc_o, dwr_addr_o, dwr_data_o;
  logic        dwr_en_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  onecyc_cpu u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_en    (load_en),
    .load_dmem  (load_dmem),
    .load_addr  (load_addr),
    .load_data  (load_data),
    .pc_o       (pc_o),
    .dwr_en_o   (dwr_en_o),
    .dwr_addr_o (dwr_addr_o),
    .dwr_data_o (dwr_data_o)
  );

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction
  function automatic logic [31:0] enc_j(int word);
    return {6'h02, 26'(word)};
  endfunction
  function automatic logic [31:0] slt_ref(logic [31:0] a, logic [31:0] b);
    return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load_word(bit to_dmem, int addr, logic [31:0] data);
    @(negedge clk);
    load_en = 1'b1; load_dmem = to_dmem; load_addr = 6'(addr); load_data = data;
    @(negedge clk);
    load_en = 1'b0;
  endtask

  task automatic load_program();
    logic [31:0] p [28];
    p[0]  = enc_i(6'h23, 0, 1, 16'd0);
    p[1]  = enc_i(6'h23, 0, 2, 16'd4);
    p[2]  = enc_r(1, 2, 3, 6'h20);
    p[3]  = enc_i(6'h2B, 0, 3, 16'd8);
    p[4]  = enc_r(1, 2, 3, 6'h22);
    p[5]  = enc_i(6'h2B, 0, 3, 16'd12);
    p[6]  = enc_r(1, 2, 3, 6'h24);
    p[7]  = enc_i(6'h2B, 0, 3, 16'd16);
    p[8]  = enc_r(1, 2, 3, 6'h25);
    p[9]  = enc_i(6'h2B, 0, 3, 16'd20);
    p[10] = enc_r(1, 2, 3, 6'h2A);
    p[11] = enc_i(6'h2B, 0, 3, 16'd24);
    p[12] = enc_i(6'h0D, 1, 3, ORI_K);
    p[13] = enc_i(6'h2B, 0, 3, 16'd28);
    p[14] = enc_i(6'h0D, 1, 0, 16'hFFFF);
    p[15] = enc_i(6'h2B, 0, 0, 16'd32);
    p[16] = enc_i(6'h04, 1, 1, 16'd1);
    p[17] = enc_i(6'h2B, 0, 1, 16'd36);
    p[18] = enc_i(6'h04, 1, 2, 16'd1);
    p[19] = enc_i(6'h2B, 0, 2, 16'd40);
    p[20] = enc_j(22);
    p[21] = enc_i(6'h2B, 0, 1, 16'd44);
    p[22] = enc_i(6'h0D, 0, 5, 16'd12);
    p[23] = enc_i(6'h23, 5, 4, 16'hFFFC);
    p[24] = enc_i(6'h2B, 0, 4, 16'd48);
    p[25] = enc_i(6'h3F, 0, 3, 16'h1234);
    p[26] = enc_i(6'h2B, 0, 3, 16'd52);
    p[27] = enc_j(27);
    for (int i = 0; i < 28; i++) load_word(1'b0, i, p[i]);
  endtask

  task automatic run_round(logic [31:0] a, logic [31:0] b);
    logic [31:0] ev_a [16];
    logic [31:0] ev_d [16];
    logic [31:0] ex_a [16];
    logic [31:0] ex_d [16];
    string       ex_t [16];
    logic [31:0] cp [64];
    logic [31:0] ep [64];
    logic [31:0] raw [STEPS];
    int nev = 0, nex = 0, ncp = 0, nep = 0;

    @(negedge clk);
    rst_n = 1'b0;
    load_word(1'b1, 0, a);
    load_word(1'b1, 1, b);
    #1;
    check(pc_o == 32'd0, "R1 pc in reset", pc_o, 32'd0);
    check(dwr_en_o == 1'b0, "R1 no store in reset", 32'(dwr_en_o), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    for (int s = 0; s < STEPS; s++) begin
      raw[s] = pc_o;
      if (ncp == 0 || cp[ncp-1] != pc_o) begin
        cp[ncp] = pc_o; ncp++;
      end
      if (dwr_en_o && nev < 16) begin
        ev_a[nev] = dwr_addr_o; ev_d[nev] = dwr_data_o; nev++;
      end
      @(negedge clk);
      #1;
    end

    // expected stores (R11: operands come from words written by the load port)
    ex_a[nex] = 8;  ex_d[nex] = a + b;           ex_t[nex] = "R3 add R11"; nex++;
    ex_a[nex] = 12; ex_d[nex] = a - b;           ex_t[nex] = "R3 sub";     nex++;
    ex_a[nex] = 16; ex_d[nex] = a & b;           ex_t[nex] = "R3 and";     nex++;
    ex_a[nex] = 20; ex_d[nex] = a | b;           ex_t[nex] = "R3 or";      nex++;
    ex_a[nex] = 24; ex_d[nex] = slt_ref(a, b);   ex_t[nex] = "R4 slt";     nex++;
    ex_a[nex] = 28; ex_d[nex] = a | {16'h0, ORI_K}; ex_t[nex] = "R5 ori zext"; nex++;
    ex_a[nex] = 32; ex_d[nex] = 32'd0;           ex_t[nex] = "R9 r0 write"; nex++;
    if (a != b) begin
      ex_a[nex] = 40; ex_d[nex] = b;             ex_t[nex] = "R7 beq fall"; nex++;
    end
    ex_a[nex] = 48; ex_d[nex] = a + b;           ex_t[nex] = "R6 lw neg offset"; nex++;
    ex_a[nex] = 52; ex_d[nex] = a | {16'h0, ORI_K}; ex_t[nex] = "R10 unknown op"; nex++;

    check(nev == nex, "R6 R10 store count", 32'(nev), 32'(nex));
    for (int i = 0; i < nex && i < nev; i++) begin
      check(ev_a[i] == ex_a[i], {ex_t[i], " addr"}, ev_a[i], ex_a[i]);
      check(ev_d[i] == ex_d[i], {ex_t[i], " data"}, ev_d[i], ex_d[i]);
    end

    // expected PC sequence, repeats collapsed
    for (int w = 0; w <= 16; w++) begin ep[nep] = 32'(w*4); nep++; end
    ep[nep] = 72; nep++;
    if (a != b) begin ep[nep] = 76; nep++; end
    ep[nep] = 80; nep++;
    for (int w = 22; w <= 27; w++) begin ep[nep] = 32'(w*4); nep++; end
    check(ncp == nep, "R7 R8 R10 pc path length", 32'(ncp), 32'(nep));
    for (int i = 0; i < nep && i < ncp; i++)
      check(cp[i] == ep[i], "R7 R8 R10 R2 pc path", cp[i], ep[i]);
    check(raw[STEPS-1] == 108 && raw[STEPS-2] == 108, "R8 self jump holds",
          raw[STEPS-1], 32'd108);
  endtask

  initial begin
    logic [31:0] ra, rb;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    load_program();
    run_round(32'd7, 32'd3);
    run_round(32'h7FFF_FFFF, 32'h8000_0000);  // R4 signed boundary
    run_round(32'hFFFF_FFFF, 32'd1);          // R4 negative less
    run_round(32'd5, 32'd5);                  // R7 second branch taken
    run_round(32'h0000_8000, 32'hFFFF_0001);
    for (int r = 0; r < 16; r++) begin
      ra = $urandom();
      rb = (r % 4 == 0) ? ra : $urandom();
      run_round(ra, rb);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule